// File: doc/BRIEF.md
# Microcontroller Sleep-Mode and Wake-Up Sequencer

This block sits next to an 8-bit controller core and decides which clocks run. A write to the power-control register moves the core from Normal into Idle or Power-down. In Idle the core clock stops and the peripheral clocks keep running. In Power-down both are gated off. The block can also put the whole chip to sleep. An arm bit in a separate system-control register is set first, and a later power-down write then raises an oscillator-stop request to the analog section. This is System-off.

Wake sources pass through a synchronizer before the sequencer uses them. Several internal event lines and the higher external interrupts are ORed onto external interrupt 0, so they share its wake path. That merged line is also brought out for the core. Idle ends on any enabled source. Power-down and System-off end only on enabled interrupt 0 or 1, or on the reset pin. Leaving System-off always restarts the chip through a fixed reset-and-settle window. During that window the clock enables return a few cycles before the core reset is released. A pin reset runs through the same window.

Top module: `pmu_sleep_ctrl`

## Requirements
- R1: After reset release, and after every System-off wake, `core_rst` stays high for exactly 4164 cycles (4096 + 64 + 4) and then goes low with the block in Normal.
- R2: Inside that window both clock enables are low for the first 4160 cycles and high for the last 4, so the clocks are running before `core_rst` falls.
- R3: A power-control write in Normal with idle=1 and pd=0 clears `core_clk_en` on the next cycle and keeps `periph_clk_en` high.
- R4: Idle returns to Normal when any enabled source is high: merged interrupt 0 with `int0_en`, `ext_irq[1]` with `int1_en`, or `aux_irq[i]` with `aux_en[i]`. A raw input reaches Normal on the third clock edge after it is driven. A source whose enable is 0 leaves Idle unchanged.
- R5: A power-down write while the arm bit is clear turns off both clock enables and leaves `osc_off_req` low. Power-down ignores auxiliary sources. It returns to Normal on enabled interrupt 0 or 1, with no core reset.
- R6: `irq0_wake` is the OR of `ext_irq[0]`, `ext_irq[6:2]` and `sys_evt[2:0]`, delayed by two clock edges. `ext_irq[1]` is not part of it.
- R7: A single write with both idle and pd set enters Power-down.
- R8: A system-control write with its off bit set arms System-off. A following power-down write raises `osc_off_req` with both clock enables low. Arming alone, or an idle write while armed, never raises `osc_off_req`.
- R9: System-off ignores auxiliary sources and disabled interrupts 0 and 1. It ends only on enabled interrupt 0, enabled interrupt 1, or the reset pin.
- R10: A System-off wake drops `osc_off_req` and raises `core_rst` in the same cycle, then runs the window of R1 and R2.
- R11: A System-off wake clears the arm bit, so the next power-down write gives plain Power-down.
- R12: Power-control writes made while the block is not in Normal are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Reset pin, active low, asynchronous |
| pctl_wr | input | 1 | Power-control register write strobe |
| pctl_idle | input | 1 | Idle request bit of the write |
| pctl_pd | input | 1 | Power-down request bit of the write |
| sysctl_wr | input | 1 | System-control register write strobe |
| sysctl_off | input | 1 | System-off arm bit of the write |
| ext_irq | input | 7 | External interrupt lines 0..6 |
| int0_en | input | 1 | Enable of merged interrupt 0 |
| int1_en | input | 1 | Enable of external interrupt 1 |
| sys_evt | input | 3 | Timebase, signal-processor and real-time-clock events |
| aux_irq | input | 5 | Two timers, serial bus, modem, frame sync |
| aux_en | input | 5 | Per-line enables of `aux_irq` |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_off_req | output | 1 | Request to stop the oscillator |
| core_rst | output | 1 | Core and chip reset, active high |
| irq0_wake | output | 1 | Synchronized merged interrupt 0 |

## Verification
The bench counts the settle window edge by edge. A counter that is off by one would move the fall of `core_rst` or the return of the clocks by a cycle, and a late clock enable would release reset onto a stopped core. The bench raises every merged line on its own. A missing OR term would then leave `irq0_wake` low, and a wrongly included `ext_irq[1]` would raise it. Each sleep state is also given sources it must not answer: disabled interrupts, auxiliary lines in Power-down and System-off, and writes made during Idle. A design that woke too readily, or that kept the arm bit across a System-off wake, would show a clock enable or `osc_off_req` at the wrong level.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   typedef enum logic [2:0] {
      PM_SETTLE = 3'd0,
      PM_RUN    = 3'd1,
      PM_IDLE   = 3'd2,
      PM_PDOWN  = 3'd3,
      PM_SYSOFF = 3'd4
   } pm_state_e;
endpackage

// File: rtl/pmu_wake_merge.sv
module pmu_wake_merge #(
   parameter int unsigned N_EXT       = 7,
   parameter int unsigned N_EVT       = 3,
   parameter int unsigned N_AUX       = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EXT-1:0] ext_irq,
   input  logic [N_EVT-1:0] sys_evt,
   input  logic [N_AUX-1:0] aux_irq,
   output logic             int0_s,
   output logic             int1_s,
   output logic [N_AUX-1:0] aux_s
);
   localparam int unsigned W = N_AUX + 2;

   logic         merged0;
   logic [W-1:0] raw;
   logic [W-1:0] synced;

   // upper external lines and internal events share interrupt 0
   assign merged0 = ext_irq[0] | (|ext_irq[N_EXT-1:2]) | (|sys_evt);
   assign raw     = {aux_irq, ext_irq[1], merged0};

   if (SYNC_STAGES == 0) begin : g_comb
      assign synced = raw;
   end else begin : g_sync
      logic [W-1:0] stg [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(SYNC_STAGES); i++) stg[i] <= '0;
         end else begin
            stg[0] <= raw;
            for (int i = 1; i < int'(SYNC_STAGES); i++) stg[i] <= stg[i-1];
         end
      end
      assign synced = stg[SYNC_STAGES-1];
   end

   assign int0_s = synced[0];
   assign int1_s = synced[1];
   assign aux_s  = synced[W-1:2];
endmodule

// File: rtl/pmu_settle_cnt.sv
module pmu_settle_cnt #(
   parameter int unsigned TOTAL     = 4164,
   parameter int unsigned CLK_ON_AT = 4160,
   parameter int unsigned CNT_W     = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done,
   output logic clk_ok
);
   logic [CNT_W-1:0] cnt;

   assign done   = (cnt == CNT_W'(TOTAL - 1));
   assign clk_ok = (cnt >= CNT_W'(CLK_ON_AT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!run)     cnt <= '0;
      else if (done)     cnt <= '0;
      else               cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pmu_mode_fsm.sv
module pmu_mode_fsm
   import pmu_pkg::*;
#(
   parameter int unsigned N_AUX = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pctl_wr,
   input  logic             pctl_idle,
   input  logic             pctl_pd,
   input  logic             sysctl_wr,
   input  logic             sysctl_off,
   input  logic             int0_s,
   input  logic             int1_s,
   input  logic [N_AUX-1:0] aux_s,
   input  logic             int0_en,
   input  logic             int1_en,
   input  logic [N_AUX-1:0] aux_en,
   input  logic             settle_done,
   output pm_state_e        state
);
   pm_state_e nxt;
   logic      armed;
   logic      wake_deep;
   logic      wake_any;

   assign wake_deep = (int0_s & int0_en) | (int1_s & int1_en);
   assign wake_any  = wake_deep | (|(aux_s & aux_en));

   always_comb begin
      nxt = state;
      unique case (state)
         PM_SETTLE: if (settle_done) nxt = PM_RUN;
         PM_RUN: begin
            if (pctl_wr) begin
               if (pctl_pd)        nxt = armed ? PM_SYSOFF : PM_PDOWN;
               else if (pctl_idle) nxt = PM_IDLE;
            end
         end
         PM_IDLE:   if (wake_any)  nxt = PM_RUN;
         PM_PDOWN:  if (wake_deep) nxt = PM_RUN;
         PM_SYSOFF: if (wake_deep) nxt = PM_SETTLE;
         default:                  nxt = PM_SETTLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PM_SETTLE;
         armed <= 1'b0;
      end else begin
         state <= nxt;
         if (state == PM_SYSOFF && wake_deep)   armed <= 1'b0;
         else if (state == PM_RUN && sysctl_wr) armed <= sysctl_off;
      end
   end
endmodule

// File: rtl/pmu_sleep_ctrl.sv
module pmu_sleep_ctrl
   import pmu_pkg::*;
#(
   parameter int unsigned N_EXT       = 7,
   parameter int unsigned N_EVT       = 3,
   parameter int unsigned N_AUX       = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OSC_WAIT    = 4096,
   parameter int unsigned LOCK_WAIT   = 64,
   parameter int unsigned CLK_LEAD    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pctl_wr,
   input  logic             pctl_idle,
   input  logic             pctl_pd,
   input  logic             sysctl_wr,
   input  logic             sysctl_off,
   input  logic [N_EXT-1:0] ext_irq,
   input  logic             int0_en,
   input  logic             int1_en,
   input  logic [N_EVT-1:0] sys_evt,
   input  logic [N_AUX-1:0] aux_irq,
   input  logic [N_AUX-1:0] aux_en,
   output logic             core_clk_en,
   output logic             periph_clk_en,
   output logic             osc_off_req,
   output logic             core_rst,
   output logic             irq0_wake
);
   localparam int unsigned SETTLE_TOTAL = OSC_WAIT + LOCK_WAIT + CLK_LEAD;
   localparam int unsigned CLK_ON_AT    = OSC_WAIT + LOCK_WAIT;
   localparam int unsigned CNT_W        = $clog2(SETTLE_TOTAL);

   if (N_EXT < 3) begin : g_bad_ext
      $error("pmu_sleep_ctrl: N_EXT must be at least 3");
   end
   if (N_EVT < 1 || N_AUX < 1) begin : g_bad_src
      $error("pmu_sleep_ctrl: N_EVT and N_AUX must be at least 1");
   end
   if (CLK_LEAD < 1) begin : g_bad_lead
      $error("pmu_sleep_ctrl: CLK_LEAD must be at least 1");
   end

   pm_state_e        state;
   logic             int0_s;
   logic             int1_s;
   logic [N_AUX-1:0] aux_s;
   logic             settle_done;
   logic             settle_clk_ok;

   pmu_wake_merge #(
      .N_EXT(N_EXT), .N_EVT(N_EVT), .N_AUX(N_AUX), .SYNC_STAGES(SYNC_STAGES)
   ) u_merge (
      .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .sys_evt(sys_evt),
      .aux_irq(aux_irq), .int0_s(int0_s), .int1_s(int1_s), .aux_s(aux_s)
   );

   pmu_settle_cnt #(
      .TOTAL(SETTLE_TOTAL), .CLK_ON_AT(CLK_ON_AT), .CNT_W(CNT_W)
   ) u_settle (
      .clk(clk), .rst_n(rst_n), .run(state == PM_SETTLE),
      .done(settle_done), .clk_ok(settle_clk_ok)
   );

   pmu_mode_fsm #(.N_AUX(N_AUX)) u_fsm (
      .clk(clk), .rst_n(rst_n), .pctl_wr(pctl_wr), .pctl_idle(pctl_idle),
      .pctl_pd(pctl_pd), .sysctl_wr(sysctl_wr), .sysctl_off(sysctl_off),
      .int0_s(int0_s), .int1_s(int1_s), .aux_s(aux_s), .int0_en(int0_en),
      .int1_en(int1_en), .aux_en(aux_en), .settle_done(settle_done),
      .state(state)
   );

   assign core_clk_en   = (state == PM_RUN) | ((state == PM_SETTLE) & settle_clk_ok);
   assign periph_clk_en = core_clk_en | (state == PM_IDLE);
   assign osc_off_req   = (state == PM_SYSOFF);
   assign core_rst      = (state == PM_SETTLE);
   assign irq0_wake     = int0_s;
endmodule

// File: rtl/pmu_sleep_ctrl_chk.sv
module pmu_sleep_ctrl_chk #(
   parameter int unsigned SETTLE_TOTAL = 4164
) (
   input logic clk,
   input logic rst_n,
   input logic pctl_wr,
   input logic pctl_pd,
   input logic core_clk_en,
   input logic periph_clk_en,
   input logic osc_off_req,
   input logic core_rst
);
   int unsigned run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_len <= 0;
      else if (core_rst) run_len <= run_len + 1;
      else               run_len <= 0;
   end

   assert_settle_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst) |-> (run_len == SETTLE_TOTAL));

   assert_clk_before_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst) |-> $past(core_clk_en));

   assert_core_implies_periph_R3: assert property (@(posedge clk) disable iff (!rst_n)
      core_clk_en |-> periph_clk_en);

   assert_osc_off_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      osc_off_req |-> (!core_clk_en && !periph_clk_en));

   assert_osc_off_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_off_req) |-> $past(pctl_wr && pctl_pd));

   assert_wake_resets_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_off_req) |-> core_rst);
endmodule

bind pmu_sleep_ctrl pmu_sleep_ctrl_chk #(.SETTLE_TOTAL(SETTLE_TOTAL)) u_chk (
   .clk(clk), .rst_n(rst_n), .pctl_wr(pctl_wr), .pctl_pd(pctl_pd),
   .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
   .osc_off_req(osc_off_req), .core_rst(core_rst)
);

// File: tb/pmu_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module pmu_sleep_ctrl_bench;
   localparam int TOT  = 4096 + 64 + 4;
   localparam int LEAD = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pctl_wr = 0, pctl_idle = 0, pctl_pd = 0;
   logic       sysctl_wr = 0, sysctl_off = 0;
   logic [6:0] ext_irq = '0;
   logic       int0_en = 0, int1_en = 0;
   logic [2:0] sys_evt = '0;
   logic [4:0] aux_irq = '0, aux_en = '0;
   logic       core_clk_en, periph_clk_en, osc_off_req, core_rst, irq0_wake;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   pmu_sleep_ctrl u_pmu_sleep_ctrl (
      .clk(clk), .rst_n(rst_n), .pctl_wr(pctl_wr), .pctl_idle(pctl_idle),
      .pctl_pd(pctl_pd), .sysctl_wr(sysctl_wr), .sysctl_off(sysctl_off),
      .ext_irq(ext_irq), .int0_en(int0_en), .int1_en(int1_en),
      .sys_evt(sys_evt), .aux_irq(aux_irq), .aux_en(aux_en),
      .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
      .osc_off_req(osc_off_req), .core_rst(core_rst), .irq0_wake(irq0_wake)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_pctl(input logic idle, input logic pd);
      pctl_wr = 1; pctl_idle = idle; pctl_pd = pd;
      tick(1);
      pctl_wr = 0; pctl_idle = 0; pctl_pd = 0;
   endtask

   task automatic wr_sysctl(input logic off);
      sysctl_wr = 1; sysctl_off = off;
      tick(1);
      sysctl_wr = 0; sysctl_off = 0;
   endtask

   // called at the negedge where the window counter sits at zero
   task automatic settle_check(input string tag);
      chk({tag, " R1 rst at start"}, core_rst, 1'b1);
      chk({tag, " R10 osc released"}, osc_off_req, 1'b0);
      tick(TOT - LEAD - 1);
      chk({tag, " R2 core clk still off"}, core_clk_en, 1'b0);
      chk({tag, " R2 periph clk still off"}, periph_clk_en, 1'b0);
      tick(1);
      chk({tag, " R2 core clk back"}, core_clk_en, 1'b1);
      chk({tag, " R2 periph clk back"}, periph_clk_en, 1'b1);
      chk({tag, " R2 rst still held"}, core_rst, 1'b1);
      tick(LEAD - 1);
      chk({tag, " R1 rst last cycle"}, core_rst, 1'b1);
      tick(1);
      chk({tag, " R1 rst released"}, core_rst, 1'b0);
      chk({tag, " R1 normal clocks"}, core_clk_en, 1'b1);
   endtask

   task automatic t_reset();
      rst_n = 0;
      tick(3);
      chk("R1 rst during pin reset", core_rst, 1'b1);
      chk("R2 clk off during pin reset", core_clk_en, 1'b0);
      chk("R8 osc req low in reset", osc_off_req, 1'b0);
      rst_n = 1;
      settle_check("pin");
   endtask

   task automatic t_idle();
      wr_pctl(1, 0);
      chk("R3 core clk off in idle", core_clk_en, 1'b0);
      chk("R3 periph clk on in idle", periph_clk_en, 1'b1);
      wr_pctl(0, 1);
      chk("R12 pd write in idle ignored", periph_clk_en, 1'b1);
      aux_irq[0] = 1;
      tick(5);
      chk("R4 disabled aux no wake", core_clk_en, 1'b0);
      aux_en[0] = 1;
      tick(1);
      chk("R4 enabled aux wakes", core_clk_en, 1'b1);
      aux_irq[0] = 0; aux_en[0] = 0;
      tick(4);
      chk("R4 stays normal after wake", core_clk_en, 1'b1);
      int0_en = 1;
      wr_pctl(1, 0);
      ext_irq[0] = 1;
      tick(2);
      chk("R4 int0 wake not yet", core_clk_en, 1'b0);
      tick(1);
      chk("R4 int0 wake third edge", core_clk_en, 1'b1);
      ext_irq[0] = 0; int0_en = 0;
      tick(4);
   endtask

   task automatic t_merge();
      for (int i = 0; i < 10; i++) begin
         if (i < 7) begin
            if (i == 1) continue;
            ext_irq[i] = 1;
         end else begin
            sys_evt[i-7] = 1;
         end
         tick(1);
         chk($sformatf("R6 line %0d one edge", i), irq0_wake, 1'b0);
         tick(1);
         chk($sformatf("R6 line %0d merged", i), irq0_wake, 1'b1);
         ext_irq = '0; sys_evt = '0;
         tick(3);
         chk($sformatf("R6 line %0d cleared", i), irq0_wake, 1'b0);
      end
      ext_irq[1] = 1;
      tick(3);
      chk("R6 ext1 not merged", irq0_wake, 1'b0);
      ext_irq[1] = 0;
      tick(3);
   endtask

   task automatic t_pdown();
      wr_pctl(1, 1);
      chk("R7 both bits gives pdown core", core_clk_en, 1'b0);
      chk("R7 both bits gives pdown periph", periph_clk_en, 1'b0);
      chk("R5 no osc req", osc_off_req, 1'b0);
      aux_irq[2] = 1; aux_en[2] = 1;
      tick(5);
      chk("R5 aux ignored in pdown", periph_clk_en, 1'b0);
      aux_irq[2] = 0; aux_en[2] = 0;
      int1_en = 1; ext_irq[1] = 1;
      tick(2);
      chk("R5 int1 wake not yet", core_clk_en, 1'b0);
      tick(1);
      chk("R5 int1 wakes pdown", core_clk_en, 1'b1);
      chk("R5 no reset on pdown wake", core_rst, 1'b0);
      ext_irq[1] = 0; int1_en = 0;
      tick(4);
   endtask

   task automatic t_sysoff();
      wr_sysctl(1);
      chk("R8 arm alone no osc req", osc_off_req, 1'b0);
      wr_pctl(1, 0);
      chk("R8 idle while armed no osc req", osc_off_req, 1'b0);
      chk("R8 idle while armed periph", periph_clk_en, 1'b1);
      aux_irq[1] = 1; aux_en[1] = 1;
      tick(3);
      aux_irq[1] = 0; aux_en[1] = 0;
      tick(4);
      chk("R4 woke from armed idle", core_clk_en, 1'b1);
      wr_pctl(0, 1);
      chk("R8 osc req raised", osc_off_req, 1'b1);
      chk("R8 core clk off", core_clk_en, 1'b0);
      chk("R8 periph clk off", periph_clk_en, 1'b0);
      aux_irq[3] = 1; aux_en[3] = 1;
      tick(5);
      chk("R9 aux ignored in sysoff", osc_off_req, 1'b1);
      aux_irq[3] = 0; aux_en[3] = 0;
      sys_evt[2] = 1;
      tick(5);
      chk("R9 disabled int0 ignored", osc_off_req, 1'b1);
      sys_evt[2] = 0;
      tick(3);
      int0_en = 1;
      sys_evt[2] = 1;
      tick(2);
      chk("R9 wake after two edges not yet", osc_off_req, 1'b1);
      tick(1);
      sys_evt[2] = 0;
      settle_check("sysoff");
      tick(3);
      int0_en = 0;
      wr_pctl(0, 1);
      chk("R11 arm cleared osc req", osc_off_req, 1'b0);
      chk("R11 plain pdown", periph_clk_en, 1'b0);
      int0_en = 1; ext_irq[0] = 1;
      tick(3);
      chk("R11 pdown woken by int0", core_clk_en, 1'b1);
      chk("R11 no reset on pdown wake", core_rst, 1'b0);
      ext_irq[0] = 0; int0_en = 0;
      tick(4);
   endtask

   task automatic t_pin_wake();
      wr_sysctl(1);
      wr_pctl(0, 1);
      chk("R8 second sysoff entry", osc_off_req, 1'b1);
      ext_irq[1] = 1;
      tick(5);
      chk("R9 disabled int1 ignored", osc_off_req, 1'b1);
      ext_irq[1] = 0;
      tick(3);
      t_reset();
      wr_pctl(0, 1);
      chk("R11 pin reset clears arm", osc_off_req, 1'b0);
      int1_en = 1; ext_irq[1] = 1;
      tick(3);
      chk("R9 int1 wakes pdown", core_clk_en, 1'b1);
      ext_irq[1] = 0; int1_en = 0;
      tick(3);
   endtask

   initial begin
      tick(1);
      t_reset();
      t_idle();
      t_merge();
      t_pdown();
      t_sysoff();
      t_pin_wake();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule